// File: doc/BRIEF.md
# Four-Channel Double-Buffered Converter Code Bank

This block keeps the codes for a group of converter channels. Every channel has two stages. A pending stage takes new words from the host side. A live stage holds the code that the converter actually uses. A host write names any subset of channels through a bit mask and carries a hold flag. When the hold flag is 1, the live stages keep their values and only the pending stages take the new word. When the hold flag is 0, the live stages take over the pending contents. This lets the host load the channels one at a time and then update all of them at once.

A channel copies into its live stage only if it has been written since its last copy. A channel that is still current is left alone, so it produces no update glitch. The two top bits of each live code choose the channel's power-down mode. This means a mode change takes effect at the same moment as the code change.

Top module: `dacbank_top`

## Requirements
- R1: A write with `wr_hold`=1 loads `wr_word` into the pending stage of every channel whose `wr_mask` bit is 1. No live code changes, and the new value only appears at `code_o` after a later write with `wr_hold`=0.
- R2: Bit i of `wr_mask` selects channel i. Several bits may be set at once. A write with an all-zero mask and `wr_hold`=1 has no effect on any output, now or after a later transfer.
- R3: On a write with `wr_hold`=0, every unselected channel that has a pending change copies its pending stage into its live stage. Every selected channel takes `wr_word` into both stages in that same edge. `code_o` shows the result in the cycle after the edge.
- R4: A channel with no pending change keeps its live code during a transfer and is not rewritten. `upd_o[i]` is 1 for exactly the one cycle after an edge that wrote live stage i, and is 0 otherwise.
- R5: `pd_o[2i+1:2i]` equals bits 15:14 of channel i's live code. The encodings are 00 normal operation, 01 power-down into a 1 kΩ load, 10 power-down into a 100 kΩ load, and 11 power-down with a high-impedance output.
- R6: While `rst_n` is 0, and in the first cycle after it is released, all stages read 0, all `upd_o` bits are 0, and every channel is in normal mode. Pending changes are cleared by reset.
- R7: A pending change is set by a pending-stage load and cleared by a copy to the live stage. A second transfer with no writes in between rewrites no channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe, one word per cycle |
| wr_mask | input | 4 | Channel select, bit i is channel i |
| wr_hold | input | 1 | 1 keeps live codes, 0 transfers |
| wr_word | input | 16 | Code word; bits 15:14 are the power-down field |
| code_o | output | 64 | Live codes, channel i in bits 16i+15:16i |
| pd_o | output | 8 | Power-down mode per channel, 2 bits each |
| upd_o | output | 4 | One-cycle pulse per rewritten live stage |

## Verification
Every result of a write appears one cycle later. The pending and live stages, the pending-change flags and the update pulses are all written at the edge that samples the write, so `code_o`, `pd_o` and `upd_o` are valid in the cycle that follows. The bench drives inputs and samples outputs on falling edges. It compares all outputs of all channels half a cycle after each writing edge, and again after an idle cycle to confirm that the pulses have ended. Pending contents are hidden, so they are checked through a later transfer that brings them onto `code_o`.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
  typedef enum logic [1:0] {
    PD_NORMAL = 2'b00,
    PD_LOAD1K = 2'b01,
    PD_LOAD100K = 2'b10,
    PD_HIZ = 2'b11
  } pd_mode_t;

  // Power-down field sits in the two most significant bits of a code.
  function automatic pd_mode_t pd_field(input logic [15:0] code);
    return pd_mode_t'(code[15:14]);
  endfunction
endpackage

// File: rtl/dacbank_strobe.sv
module dacbank_strobe #(
  parameter int NCH = 4
) (
  input  logic           wr_en,
  input  logic [NCH-1:0] wr_mask,
  input  logic           wr_hold,
  output logic [NCH-1:0] hit_o,
  output logic           xfer_o
);
  always_comb begin
    xfer_o = wr_en & ~wr_hold;
    for (int i = 0; i < NCH; i++) hit_o[i] = wr_en & wr_mask[i];
  end
endmodule

// File: rtl/dacbank_chan.sv
module dacbank_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit,
  input  logic         xfer,
  input  logic [W-1:0] din,
  output logic [W-1:0] code_o,
  output logic [1:0]   pd_o,
  output logic         upd_o
);
  import dacbank_pkg::*;

  logic [W-1:0] pend_q, live_q;
  logic         dirty_q, upd_q;
  logic         take_new, take_pend, write_live;

  assign take_new   = hit & xfer;
  assign take_pend  = xfer & ~hit & dirty_q;
  assign write_live = take_new | take_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      live_q  <= '0;
      dirty_q <= 1'b0;
      upd_q   <= 1'b0;
    end else begin
      if (hit) pend_q <= din;
      if (take_new) live_q <= din;
      else if (take_pend) live_q <= pend_q;
      dirty_q <= write_live ? 1'b0 : (dirty_q | hit);
      upd_q   <= write_live;
    end
  end

  assign code_o = live_q;
  assign pd_o   = pd_field(16'(live_q));
  assign upd_o  = upd_q;

  assert_hold_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(live_q));
  assert_pend_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !hit && dirty_q) |=> live_q == $past(pend_q));
  assert_direct_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && hit) |=> (live_q == $past(din) && upd_q));
  assert_clean_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !hit && !dirty_q) |=> (!upd_q && $stable(live_q)));
  assert_dirty_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !xfer) |=> dirty_q);
  assert_pulse_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |-> !dirty_q);
endmodule

// File: rtl/dacbank_top.sv
module dacbank_top #(
  parameter int NCH = 4,
  parameter int W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [NCH-1:0]   wr_mask,
  input  logic             wr_hold,
  input  logic [W-1:0]     wr_word,
  output logic [NCH*W-1:0] code_o,
  output logic [NCH*2-1:0] pd_o,
  output logic [NCH-1:0]   upd_o
);
  logic [NCH-1:0] hit;
  logic           xfer;

  dacbank_strobe #(.NCH(NCH)) strobe_i (
    .wr_en(wr_en), .wr_mask(wr_mask), .wr_hold(wr_hold),
    .hit_o(hit), .xfer_o(xfer)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dacbank_chan #(.W(W)) chan_i (
      .clk(clk), .rst_n(rst_n), .hit(hit[g]), .xfer(xfer), .din(wr_word),
      .code_o(code_o[g*W +: W]), .pd_o(pd_o[g*2 +: 2]), .upd_o(upd_o[g])
    );
  end

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> upd_o == '0);
  assert_hold_no_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hold) |=> upd_o == '0);
endmodule

// File: tb/dacbank_top_tb_top.sv
module dacbank_top_tb_top;
  localparam int NCH = 4;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [NCH-1:0] wr_mask = '0;
  logic wr_hold = 1'b1;
  logic [W-1:0] wr_word = '0;
  logic [NCH*W-1:0] code_o;
  logic [NCH*2-1:0] pd_o;
  logic [NCH-1:0] upd_o;

  int n_chk = 0, n_bad = 0;
  logic [W-1:0] pend_m [NCH];
  logic [W-1:0] live_m [NCH];
  logic dirty_m [NCH];
  logic [NCH-1:0] upd_m;

  always #5 clk = ~clk;

  dacbank_top #(.NCH(NCH), .W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mask(wr_mask),
    .wr_hold(wr_hold), .wr_word(wr_word), .code_o(code_o), .pd_o(pd_o),
    .upd_o(upd_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < NCH; i++) begin
      chk({tag, " code"}, 64'(code_o[i*W +: W]), 64'(live_m[i]));
      // R5: mode = top two bits of live code
      chk("R5 pd", 64'(pd_o[i*2 +: 2]), 64'(live_m[i] >> (W-2)));
    end
    chk("R4 upd", 64'(upd_o), 64'(upd_m));
  endtask

  task automatic model_reset();
    for (int i = 0; i < NCH; i++) begin
      pend_m[i] = '0; live_m[i] = '0; dirty_m[i] = 1'b0;
    end
    upd_m = '0;
  endtask

  task automatic op(input logic [NCH-1:0] m, input logic [W-1:0] w, input logic h, input string tag);
    wr_en = 1'b1; wr_mask = m; wr_word = w; wr_hold = h;
    upd_m = '0;
    for (int i = 0; i < NCH; i++) begin
      if (m[i]) pend_m[i] = w;
      if (!h && m[i]) begin
        live_m[i] = w; dirty_m[i] = 1'b0; upd_m[i] = 1'b1;
      end else if (!h && dirty_m[i]) begin
        live_m[i] = pend_m[i]; dirty_m[i] = 1'b0; upd_m[i] = 1'b1;
      end else if (m[i]) dirty_m[i] = 1'b1;
    end
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    check_all(tag);
  endtask

  task automatic idle(input string tag);
    upd_m = '0;
    @(posedge clk); @(negedge clk);
    check_all(tag);
  endtask

  function automatic logic [W-1:0] mkword(input int pd, input int ch, input int salt);
    return {2'(pd), 14'(ch * 997 + pd * 31 + salt + 1)};
  endfunction

  initial begin
    model_reset();
    #1;
    check_all("R6 in reset");
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    idle("R6 after release");

    // Sweep all modes on all channels: staged loads, then a group transfer.
    for (int pd = 0; pd < 4; pd++) begin
      for (int ch = 0; ch < NCH; ch++) op(4'(1 << ch), mkword(pd, ch, 0), 1'b1, "R1 staged");
      op('0, '0, 1'b0, "R3 transfer");
      op('0, '0, 1'b0, "R7 second transfer");
      idle("R4 idle");
    end

    // Partial dirty set plus direct targeted write during transfer.
    op(4'b0010, mkword(1, 7, 3), 1'b1, "R1 stage ch1");
    op(4'b1000, mkword(2, 9, 5), 1'b1, "R1 stage ch3");
    op(4'b0101, mkword(3, 4, 8), 1'b0, "R3 direct+pending");
    idle("R4 idle");

    // Multi-bit mask staging.
    op(4'b1010, mkword(0, 2, 11), 1'b1, "R2 multi stage");
    op(4'b1010, mkword(2, 3, 13), 1'b1, "R2 restage");
    op('0, '0, 1'b0, "R2 multi transfer");

    // Empty-mask hold write has no effect, now or later.
    op('0, 16'hFFFF, 1'b1, "R2 empty mask");
    op('0, '0, 1'b0, "R2 empty then transfer");

    // Rewriting a channel with a staged value then directly in one edge.
    op(4'b0001, mkword(1, 1, 21), 1'b1, "R1 stage ch0");
    op(4'b0001, mkword(3, 1, 22), 1'b0, "R3 direct over pending");
    op('0, '0, 1'b0, "R7 clean after direct");

    // Reset mid-run clears pending changes too.
    op(4'b1111, mkword(2, 5, 30), 1'b1, "R1 stage all");
    rst_n = 1'b0;
    model_reset();
    #1;
    check_all("R6 mid reset");
    @(negedge clk);
    rst_n = 1'b1;
    op('0, '0, 1'b0, "R6 no pending after reset");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule